// File: doc/BRIEF.md
# Management Receive Frame Steering

This block sits behind the MAC receive path and makes one routing decision per incoming frame. A frame is presented as a parsed header: the first EtherType field, the type field that follows a single VLAN tag, the result of MAC address filtering and the result of the other wake-up filters. The header is qualified by a one-cycle frame strobe. One clock later the block pulses at most one of three outputs. The frame goes to the sideband management agent, goes to the host on the normal receive path, or becomes a power-management wake event.

A frame can reach the management agent only when the agent has enabled management receive. In addition, the device must be either forced into management mode or in a low-power state (D1, D2 or D3). A mode bit selects what the agent receives. In management-only mode it receives only management frames: Type II frames whose type, taken after an optional VLAN tag, equals a programmable value. In the other mode it receives every frame that passes address filtering.

Recognising a frame as a management frame takes priority over all wake-up filters. If management receive is disabled, such a frame can still wake the system, but only when the wake configuration allows it. Two saturating counters track deliveries. The receive counter counts every delivered frame. The management counter counts only frames delivered to the agent.

Top module: `mgmt_rx_steer`

## Requirements
- R1: With the management-only bit at 1, management receive enabled, and either the force bit at 1 or the power state nonzero, a frame whose effective type equals `mgmt_type` pulses `to_mgmt` for exactly one cycle, in the cycle after `frame_valid`.
- R2: While `mgmt_rx_en` is 0, no frame pulses `to_mgmt`.
- R3: The effective type is `type_inner` when `type_outer` equals 16'h8100, and `type_outer` otherwise; `type_inner` has no effect on an untagged frame.
- R4: In a low-power state, a frame recognised as a management frame never raises `wake_evt` because of `wake_match`.
- R5: In a low-power state with `mgmt_rx_en` at 0, a management frame raises `wake_evt` if `wake_on_mgmt` is 1 and raises nothing if it is 0.
- R6: In a low-power state, a frame that is not a management frame and is not delivered to the agent raises `wake_evt` exactly when `wake_match` is 1.
- R7: With the management-only bit at 0, enable at 1 and the management window open, every frame with `addr_pass` at 1 goes to the agent, and a frame with `addr_pass` at 0 goes nowhere.
- R8: With the force bit at 0 and the power state at 0 (D0), a frame with `addr_pass` at 1 pulses `to_host`, and nothing ever goes to the agent or raises a wake event.
- R9: `rx_count` increments by one for each `to_mgmt` or `to_host` pulse. `mgmt_count` increments by one only for each `to_mgmt` pulse. Both change in the same cycle as the pulse.
- R10: Both counters stop at their all-ones value and never wrap.
- R11: After reset, all three pulse outputs and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | One-cycle strobe qualifying the header inputs |
| type_outer | input | 16 | First EtherType/TPID field of the frame |
| type_inner | input | 16 | Type field following a VLAN tag |
| addr_pass | input | 1 | Frame passed MAC address filtering |
| wake_match | input | 1 | Frame matched another wake-up filter |
| pwr_state | input | 2 | Power state: 0 = D0, 1..3 = D1..D3 |
| force_mgmt | input | 1 | Forced management mode |
| mgmt_rx_en | input | 1 | Management agent receive enable |
| wake_on_mgmt | input | 1 | Management frame may wake when receive is disabled |
| mgmt_only | input | 1 | 1: agent gets management frames only; 0: address-filtered frames |
| mgmt_type | input | 16 | Programmable management EtherType |
| to_mgmt | output | 1 | Frame delivered to management agent (pulse) |
| to_host | output | 1 | Frame delivered on normal path (pulse) |
| wake_evt | output | 1 | Power-management wake event (pulse) |
| rx_count | output | CNT_W | Saturating count of all delivered frames |
| mgmt_count | output | CNT_W | Saturating count of frames delivered to agent |

## Verification
The bench builds the block with `CNT_W` set to 4, so both counters reach their all-ones stop value of 15 after a few dozen frames. This makes the saturation behaviour of R10 observable for the receive counter and for the management counter separately. The bench also checks that the management counter stays frozen while host deliveries continue. The routing cases are swept over D0, forced mode and each low-power state, with the enable, wake and mode bits toggled one at a time.

// File: rtl/mgmt_rx_steer.sv
module mgmt_rx_steer #(
  parameter int          CNT_W     = 32,
  parameter logic [15:0] VLAN_TPID = 16'h8100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_valid,
  input  logic [15:0]      type_outer,
  input  logic [15:0]      type_inner,
  input  logic             addr_pass,
  input  logic             wake_match,
  input  logic [1:0]       pwr_state,
  input  logic             force_mgmt,
  input  logic             mgmt_rx_en,
  input  logic             wake_on_mgmt,
  input  logic             mgmt_only,
  input  logic [15:0]      mgmt_type,
  output logic             to_mgmt,
  output logic             to_host,
  output logic             wake_evt,
  output logic [CNT_W-1:0] rx_count,
  output logic [CNT_W-1:0] mgmt_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [15:0] eff_type;
  logic        is_mgmt, low_pwr, window, pick, dlv_mgmt, dlv_host, raise_wake;

  assign eff_type = (type_outer == VLAN_TPID) ? type_inner : type_outer;
  assign is_mgmt  = (eff_type == mgmt_type);
  assign low_pwr  = (pwr_state != 2'd0);
  assign window   = force_mgmt | low_pwr;
  assign pick     = mgmt_only ? is_mgmt : addr_pass;

  assign dlv_mgmt   = frame_valid & window & mgmt_rx_en & pick;
  assign dlv_host   = frame_valid & ~window & addr_pass;
  assign raise_wake = frame_valid & low_pwr & ~dlv_mgmt &
                      (is_mgmt ? (~mgmt_rx_en & wake_on_mgmt) : wake_match);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      to_mgmt    <= 1'b0;
      to_host    <= 1'b0;
      wake_evt   <= 1'b0;
      rx_count   <= '0;
      mgmt_count <= '0;
    end else begin
      to_mgmt  <= dlv_mgmt;
      to_host  <= dlv_host;
      wake_evt <= raise_wake;
      if ((dlv_mgmt | dlv_host) && rx_count != CNT_MAX)
        rx_count <= rx_count + 1'b1;
      if (dlv_mgmt && mgmt_count != CNT_MAX)
        mgmt_count <= mgmt_count + 1'b1;
    end
  end
endmodule

module mgmt_rx_steer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_valid,
  input logic [1:0]       pwr_state,
  input logic             force_mgmt,
  input logic             mgmt_rx_en,
  input logic             to_mgmt,
  input logic             to_host,
  input logic             wake_evt,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] mgmt_count
);
  a_r1_pulse_follows_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (to_mgmt || to_host || wake_evt) |-> $past(frame_valid));

  a_r2_no_mgmt_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !mgmt_rx_en) |=> !to_mgmt);

  a_r8_d0_host_only: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !force_mgmt && pwr_state == 2'd0) |=> (!to_mgmt && !wake_evt));

  a_r9_single_route: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({to_mgmt, to_host, wake_evt}) <= 1);

  a_r9_mgmt_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !to_mgmt |-> mgmt_count == $past(mgmt_count));

  a_r9_rx_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!to_mgmt && !to_host) |-> rx_count == $past(rx_count));

  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count >= $past(rx_count)) && (mgmt_count >= $past(mgmt_count)));
endmodule

bind mgmt_rx_steer mgmt_rx_steer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .pwr_state(pwr_state),
  .force_mgmt(force_mgmt), .mgmt_rx_en(mgmt_rx_en), .to_mgmt(to_mgmt),
  .to_host(to_host), .wake_evt(wake_evt), .rx_count(rx_count),
  .mgmt_count(mgmt_count)
);

// File: tb/mgmt_rx_steer_bench.sv
module mgmt_rx_steer_bench;
  localparam int CNT_W = 4;
  localparam int CMAX  = 15;
  localparam logic [15:0] MT = 16'h8899;

  logic clk = 0, rst_n = 0, frame_valid = 0;
  logic [15:0] type_outer = 0, type_inner = 0, mgmt_type = MT;
  logic addr_pass = 0, wake_match = 0, force_mgmt = 0, mgmt_rx_en = 0;
  logic wake_on_mgmt = 0, mgmt_only = 1;
  logic [1:0] pwr_state = 0;
  logic to_mgmt, to_host, wake_evt;
  logic [CNT_W-1:0] rx_count, mgmt_count;

  int total = 0, bad = 0, exp_rx = 0, exp_mg = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mgmt_rx_steer #(.CNT_W(CNT_W)) u_mgmt_rx_steer (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input bit f, input logic [1:0] p, input bit en, input bit wo, input bit mo);
    @(negedge clk);
    force_mgmt = f; pwr_state = p; mgmt_rx_en = en; wake_on_mgmt = wo; mgmt_only = mo;
  endtask

  task automatic send(input string tag, input logic [15:0] o, input logic [15:0] i,
                      input bit ap, input bit wm, input bit em, input bit eh, input bit ew);
    @(negedge clk);
    type_outer = o; type_inner = i; addr_pass = ap; wake_match = wm; frame_valid = 1;
    @(negedge clk);
    frame_valid = 0;
    if (em || eh) exp_rx = (exp_rx < CMAX) ? exp_rx + 1 : CMAX;
    if (em)       exp_mg = (exp_mg < CMAX) ? exp_mg + 1 : CMAX;
    chk({tag, " to_mgmt"}, int'(to_mgmt), int'(em));
    chk({tag, " to_host"}, int'(to_host), int'(eh));
    chk({tag, " wake_evt"}, int'(wake_evt), int'(ew));
    chk({tag, " R9 rx_count"}, int'(rx_count), exp_rx);
    chk({tag, " R9 mgmt_count"}, int'(mgmt_count), exp_mg);
    @(negedge clk);
    chk({tag, " R1 single pulse"}, int'(to_mgmt | to_host | wake_evt), 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R11 pulses", int'({to_mgmt, to_host, wake_evt}), 0);
    chk("R11 rx_count", int'(rx_count), 0);
    chk("R11 mgmt_count", int'(mgmt_count), 0);
    rst_n = 1;
  endtask

  task automatic t_forced;
    cfg(1, 0, 1, 0, 1);
    send("R1 forced mgmt", MT, 16'h0, 0, 0, 1, 0, 0);
    send("R1 forced other", 16'h0800, 16'h0, 1, 1, 0, 0, 0);
    cfg(0, 2, 1, 0, 1);
    send("R1 D2 mgmt", MT, 16'h0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_vlan;
    cfg(1, 0, 1, 0, 1);
    send("R3 tagged mgmt", 16'h8100, MT, 0, 0, 1, 0, 0);
    send("R3 tagged other", 16'h8100, 16'h0800, 0, 0, 0, 0, 0);
    send("R3 untagged inner ignored", 16'h0800, MT, 0, 0, 0, 0, 0);
  endtask

  task automatic t_disabled;
    cfg(0, 3, 0, 1, 1);
    send("R5 off wake on", MT, 16'h0, 1, 0, 0, 0, 1);
    send("R2 off tagged", 16'h8100, MT, 1, 0, 0, 0, 1);
    cfg(0, 3, 0, 0, 1);
    send("R5 off wake off", MT, 16'h0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_priority;
    cfg(0, 3, 0, 0, 1);
    send("R4 off filter hit", MT, 16'h0, 0, 1, 0, 0, 0);
    cfg(0, 2, 1, 0, 1);
    send("R4 on filter hit", MT, 16'h0, 0, 1, 1, 0, 0);
  endtask

  task automatic t_wake;
    cfg(0, 1, 1, 0, 1);
    send("R6 filter hit", 16'h0800, 16'h0, 1, 1, 0, 0, 1);
    send("R6 filter miss", 16'h0800, 16'h0, 1, 0, 0, 0, 0);
  endtask

  task automatic t_fwd_all;
    cfg(0, 3, 1, 0, 0);
    send("R7 addr pass", 16'h0800, 16'h0, 1, 0, 1, 0, 0);
    send("R7 addr fail", 16'h0800, 16'h0, 0, 0, 0, 0, 0);
    cfg(0, 3, 0, 0, 0);
    send("R2 fwd-all off", 16'h0800, 16'h0, 1, 0, 0, 0, 0);
  endtask

  task automatic t_normal;
    cfg(0, 0, 1, 1, 1);
    send("R8 host pass", 16'h0800, 16'h0, 1, 0, 0, 1, 0);
    send("R8 host fail", 16'h0800, 16'h0, 0, 1, 0, 0, 0);
    send("R8 mgmt in D0", MT, 16'h0, 1, 1, 0, 1, 0);
  endtask

  task automatic t_saturate;
    cfg(0, 0, 1, 0, 1);
    for (int k = 0; k < 18; k++) send("R10 host sat", 16'h0800, 16'h0, 1, 0, 0, 1, 0);
    cfg(1, 0, 1, 0, 1);
    for (int k = 0; k < 18; k++) send("R10 mgmt sat", MT, 16'h0, 0, 0, 1, 0, 0);
    chk("R10 rx stop", int'(rx_count), CMAX);
    chk("R10 mgmt stop", int'(mgmt_count), CMAX);
  endtask

  initial begin
    t_reset();
    t_forced();
    t_vlan();
    t_disabled();
    t_priority();
    t_wake();
    t_fwd_all();
    t_normal();
    t_saturate();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule